// File: doc/BRIEF.md
# Delta-Coded Bus Trace Packer

This block sits behind a bus trace capture stage. Each captured record is an address and a data value, marked by a valid strobe. The block codes each of the two fields against the previous value of that same field. A small change becomes a short signed step. A large change is written out as the full value. The resulting packets have variable length, and the block concatenates them into 32-bit words for a trace memory write port.

Whenever the selected trace mode differs from the last mode recorded, a mode packet goes into the stream, so a decoder knows where the capture granularity changed. A write-address counter tracks how full the trace memory is. When the last location is written, an interrupt is raised and further writes are suppressed. This lets a processor drain the memory off chip and then restart the trace with a clear pulse.

A flush request pads the final partial word with zeros, so that a software decoder can read the complete stream.

Top module: `trace_squeezer`

## Requirements
- R1: Every packet starts with a 2-bit kind code in its least significant bits, followed by its payload: 00 = short step with an 8-bit two's-complement payload (10 bits in total), 01 = full 32-bit value (34 bits in total), 10 = mode packet with a 4-bit mode (6 bits in total), 11 = never produced.
- R2: A field is coded as a short step exactly when (current − previous) taken modulo 2^32 lies within −128..+127 as a signed number. Otherwise it is coded as a full value. Both previous values are 0 after reset.
- R3: The previous value of a field is replaced by the current value on every record, whichever form was emitted. The decoder rebuilds each value exactly, as previous + sign-extended step or as the literal.
- R4: Within a record, the address packet comes before the data packet. When `trace_mode` differs from the last recorded mode (0 after reset), a mode packet carrying the new mode is emitted in that cycle, whether or not a record is present. It comes before any record packets of the same cycle.
- R5: Packets are packed least-significant-bit first. The first packet after reset begins at bit 0 of the first word, and each later packet starts at the bit that follows the previous one. A word is written whenever 32 or more bits are pending.
- R6: While `flush_req` is applied, any partial word is written out with zero bits above the pending bits. After a flush, the stream holds exactly ceil(bits/32) words.
- R7: After reset, `mem_we`=0, `irq_full`=0 and `mem_addr`=0. Each write goes to the next address, counting up from 0.
- R8: `irq_full` rises in the same cycle as the write to address DEPTH−1. It stays high, and no write occurs, until `irq_clear`.
- R9: A pulse on `irq_clear` returns `mem_addr` to 0 and drops `irq_full` at the following clock edge.
- R10: The first word produced by a record is presented on `mem_we`/`mem_wdata` two clock edges after the edge that samples the record.
- R11: With at most one record every three cycles, the number of pending bits never exceeds the holding register width HOLD_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid | input | 1 | A trace record is present this cycle |
| rec_addr | input | 32 | Captured address field |
| rec_data | input | 32 | Captured data field |
| trace_mode | input | 4 | Current trace mode; any change emits a mode packet |
| flush_req | input | 1 | Write out a zero-padded partial word |
| irq_clear | input | 1 | Restart the write counter after draining |
| mem_we | output | 1 | Trace memory write enable |
| mem_addr | output | log2(DEPTH) | Trace memory write address |
| mem_wdata | output | 32 | Trace memory write word |
| irq_full | output | 1 | Trace memory full interrupt |

## Verification
A record or a mode change is captured into the coding register at one edge and appended to the packer at the next. Its first word is therefore visible after the second edge, and the bench checks that `mem_we` is still low after the first edge and high after the second. A clear acts at the edge after it is applied. The full interrupt shows in the same cycle as the last write, so the write monitor compares `irq_full` with the address of every write it observes. All outputs are sampled at the falling edge, and inputs change shortly after the rising edge. The full stream is decoded independently of the design and compared packet by packet with the records and mode changes that were sent.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
    typedef enum logic [1:0] {
        HDR_STEP = 2'b00,
        HDR_FULL = 2'b01,
        HDR_MODE = 2'b10,
        HDR_RSVD = 2'b11
    } hdr_e;
endpackage

// File: rtl/tsq_delta.sv
module tsq_delta import tsq_pkg::*; #(
    parameter int VAL_W   = 32,
    parameter int STEP_W  = 8,
    parameter int LEN_W   = 8,
    localparam int PKT_W  = VAL_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [VAL_W-1:0] cur,
    output logic [PKT_W-1:0] pkt,
    output logic [LEN_W-1:0] pkt_len
);
    logic [VAL_W-1:0] prev_d, prev_q;
    logic [VAL_W-1:0] diff;
    logic             fits;

    always_comb begin
        diff   = cur - prev_q;
        fits   = (&diff[VAL_W-1:STEP_W-1]) || ~(|diff[VAL_W-1:STEP_W-1]);
        prev_d = take ? cur : prev_q;
        if (fits) begin
            pkt     = {{(PKT_W-STEP_W-2){1'b0}}, diff[STEP_W-1:0], HDR_STEP};
            pkt_len = LEN_W'(STEP_W + 2);
        end else begin
            pkt     = {cur, HDR_FULL};
            pkt_len = LEN_W'(PKT_W);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // R3: the reference value follows every record
    assert_prev_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> prev_q == $past(cur));
    // R2: a short step only when the change fits the signed step range
    assert_step_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pkt[1:0] == HDR_STEP) |=>
        ((prev_q - $past(prev_q)) + VAL_W'(2**(STEP_W-1))) < VAL_W'(2**STEP_W));
endmodule

// File: rtl/tsq_packer.sv
module tsq_packer #(
    parameter int IN_W   = 74,
    parameter int LEN_W  = 8,
    parameter int WORD_W = 32,
    parameter int HOLD_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   in_bits,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              in_flush,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);
    typedef struct packed {
        logic [HOLD_W-1:0] hold;
        logic [LEN_W-1:0]  cnt;
        logic              vld;
        logic [WORD_W-1:0] word;
    } pk_t;

    pk_t            s_d, s_q;
    logic [LEN_W:0] tot;
    logic [HOLD_W-1:0] merged;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        tot     = {1'b0, s_q.cnt} + {1'b0, in_len};
        merged  = s_q.hold | (HOLD_W'(in_bits) << s_q.cnt);
        if (tot >= (LEN_W+1)'(WORD_W) || (in_flush && tot != '0)) begin
            s_d.vld  = 1'b1;
            s_d.word = merged[WORD_W-1:0];
            merged   = merged >> WORD_W;
            tot      = (tot >= (LEN_W+1)'(WORD_W)) ? tot - (LEN_W+1)'(WORD_W) : '0;
        end
        s_d.hold = merged;
        s_d.cnt  = tot[LEN_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign out_word  = s_q.word;

    // R11: pending bits never exceed the holding register
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, s_q.cnt} + {1'b0, in_len}) <= (LEN_W+1)'(HOLD_W));
    // R6: a flush with a partial word pending writes it out
    assert_flush_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_flush && s_q.cnt != '0) |=> out_valid);
endmodule

// File: rtl/tsq_fill.sv
module tsq_fill #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              clear,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              irq
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          full;
    } fl_t;

    fl_t  s_d, s_q;
    logic at_last;

    always_comb begin
        mem_we    = wr_valid && !s_q.full;
        at_last   = s_q.addr == LAST;
        irq       = s_q.full || (mem_we && at_last);
        mem_addr  = s_q.addr;
        mem_wdata = wr_word;
        s_d       = s_q;
        if (clear) begin
            s_d = '0;
        end else if (mem_we) begin
            if (at_last) s_d.full = 1'b1;
            else         s_d.addr = s_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7: consecutive writes go to consecutive addresses
    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !clear && mem_addr != LAST) |=> mem_addr == $past(mem_addr) + 1'b1);
    // R8: the interrupt holds until cleared, with no writes meanwhile
    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clear) |=> (irq && !mem_we));
    // R9: a clear restarts the counter
    assert_clear_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> mem_addr == '0);
endmodule

// File: rtl/trace_squeezer.sv
module trace_squeezer import tsq_pkg::*; #(
    parameter int VAL_W   = 32,
    parameter int STEP_W  = 8,
    parameter int MODE_W  = 4,
    parameter int WORD_W  = 32,
    parameter int HOLD_W  = 128,
    parameter int DEPTH   = 64,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    input  logic [VAL_W-1:0]  rec_addr,
    input  logic [VAL_W-1:0]  rec_data,
    input  logic [MODE_W-1:0] trace_mode,
    input  logic              flush_req,
    input  logic              irq_clear,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              irq_full
);
    localparam int NFIELD   = 2;
    localparam int PKT_W    = VAL_W + 2;
    localparam int MODE_LEN = MODE_W + 2;
    localparam int STEP_LEN = STEP_W + 2;
    localparam int REC_W    = MODE_LEN + NFIELD * PKT_W;
    localparam int LEN_W    = $clog2(HOLD_W + 1);

    typedef struct packed {
        logic [REC_W-1:0]  bits;
        logic [LEN_W-1:0]  len;
        logic              flush;
        logic [MODE_W-1:0] mode;
    } st_t;

    st_t              st_d, st_q;
    logic [VAL_W-1:0] fval [NFIELD];
    logic [PKT_W-1:0] fpkt [NFIELD];
    logic [LEN_W-1:0] flen [NFIELD];
    logic             pk_valid;
    logic [WORD_W-1:0] pk_word;

    assign fval[0] = rec_addr;
    assign fval[1] = rec_data;

    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        tsq_delta #(.VAL_W(VAL_W), .STEP_W(STEP_W), .LEN_W(LEN_W)) u_delta (
            .clk(clk), .rst_n(rst_n), .take(rec_valid), .cur(fval[g]),
            .pkt(fpkt[g]), .pkt_len(flen[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.bits  = '0;
        st_d.len   = '0;
        st_d.flush = flush_req;
        if (trace_mode != st_q.mode) begin
            st_d.bits = REC_W'({trace_mode, HDR_MODE});
            st_d.len  = LEN_W'(MODE_LEN);
            st_d.mode = trace_mode;
        end
        if (rec_valid) begin
            for (int f = 0; f < NFIELD; f++) begin
                st_d.bits = st_d.bits | (REC_W'(fpkt[f]) << st_d.len);
                st_d.len  = st_d.len + flen[f];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tsq_packer #(.IN_W(REC_W), .LEN_W(LEN_W), .WORD_W(WORD_W), .HOLD_W(HOLD_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .in_bits(st_q.bits), .in_len(st_q.len),
        .in_flush(st_q.flush), .out_valid(pk_valid), .out_word(pk_word)
    );

    tsq_fill #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fill (
        .clk(clk), .rst_n(rst_n), .wr_valid(pk_valid), .wr_word(pk_word),
        .clear(irq_clear), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .irq(irq_full)
    );

    // R4: a changed mode is recorded first in the coded group
    assert_mode_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_mode != st_q.mode) |=> st_q.bits[1:0] == HDR_MODE);
    // R1: a record yields at least two short packets
    assert_rec_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> st_q.len >= LEN_W'(NFIELD * STEP_LEN));
endmodule

// File: tb/sim_trace_squeezer.sv
`timescale 1ns/1ps
module sim_trace_squeezer;
    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0, rst_n = 1'b0;
    logic rec_valid = 1'b0, flush_req = 1'b0, irq_clear = 1'b0;
    logic [31:0] rec_addr = '0, rec_data = '0;
    logic [3:0]  trace_mode = '0;
    logic mem_we, irq_full;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;

    int nchk = 0, nerr = 0;
    logic [31:0] strm [64];
    int nwords = 0, exp_waddr = 0, after_full = 0;
    bit capture = 1'b1, irq_seen = 1'b0, done = 1'b0;
    // expected item list: kind 0 = record, 1 = mode
    int ek [64];
    logic [31:0] ea [64], ed [64];
    logic [3:0] em [64];
    bit esa [64], esd [64];
    int n_exp = 0;
    logic [31:0] bp_a = '0, bp_d = '0;
    logic [3:0] cur_mode = '0;

    trace_squeezer #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_addr(rec_addr),
        .rec_data(rec_data), .trace_mode(trace_mode), .flush_req(flush_req),
        .irq_clear(irq_clear), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .irq_full(irq_full)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            chk(int'(mem_addr) == exp_waddr, "R7 write address", 32'(mem_addr), 32'(exp_waddr));
            chk(irq_full == (int'(mem_addr) == DEPTH-1), "R8 irq with last write", 32'(irq_full), 32'(int'(mem_addr) == DEPTH-1));
            if (capture && nwords < 64) begin strm[nwords] = mem_wdata; nwords++; end
            exp_waddr++;
            if (irq_seen) after_full++;
        end
        if (rst_n && irq_full) irq_seen = 1'b1;
    end

    function automatic logic [31:0] getb(int p, int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) begin
            int b = p + i;
            if (b / 32 < nwords) r[i] = strm[b/32][b%32];
        end
        return r;
    endfunction

    function automatic bit fits(logic [31:0] d);
        return ($signed(d) >= -128) && ($signed(d) <= 127);
    endfunction

    task automatic send_rec(input logic [31:0] a, input logic [31:0] d);
        if (capture) begin
            ek[n_exp] = 0; ea[n_exp] = a; ed[n_exp] = d;
            esa[n_exp] = fits(a - bp_a); esd[n_exp] = fits(d - bp_d);
            n_exp++;
        end
        bp_a = a; bp_d = d;
        @(posedge clk); #2;
        rec_valid = 1'b1; rec_addr = a; rec_data = d;
        @(posedge clk); #2;
        rec_valid = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    task automatic set_mode(input logic [3:0] m);
        if (m != cur_mode) begin ek[n_exp] = 1; em[n_exp] = m; n_exp++; end
        cur_mode = m;
        @(posedge clk); #2;
        trace_mode = m;
    endtask

    task automatic t_reset;
        #5;
        chk(mem_we == 1'b0, "R7 reset we", 32'(mem_we), 0);
        chk(irq_full == 1'b0, "R7 reset irq", 32'(irq_full), 0);
        chk(mem_addr == '0, "R7 reset addr", 32'(mem_addr), 0);
    endtask

    task automatic t_latency;
        logic [31:0] a = 32'h1000_0000, d = 32'hDEAD_BEEF;
        ek[n_exp] = 0; ea[n_exp] = a; ed[n_exp] = d; esa[n_exp] = 0; esd[n_exp] = 0; n_exp++;
        bp_a = a; bp_d = d;
        @(posedge clk); #2;
        rec_valid = 1'b1; rec_addr = a; rec_data = d;
        @(posedge clk); #2;
        rec_valid = 1'b0;
        @(negedge clk);
        chk(mem_we == 1'b0, "R10 no word after one edge", 32'(mem_we), 0);
        @(negedge clk);
        chk(mem_we == 1'b1, "R10 word after two edges", 32'(mem_we), 1);
        chk(mem_wdata == {a[29:0], 2'b01}, "R5 R1 first word layout", mem_wdata, {a[29:0], 2'b01});
        repeat (3) @(posedge clk);
    endtask

    task automatic t_deltas;
        send_rec(32'h1000_0004, 32'hDEAD_BEEF + 32'd127);
        send_rec(32'h1000_0083, 32'hDEAD_BEEF - 32'd1);
        send_rec(32'h1000_0103, 32'hDEAD_BEEF - 32'd130);
        set_mode(4'd3);
        send_rec(32'h1000_0102, 32'hDEAD_BEEF - 32'd129);
        send_rec(32'hFFFF_FFF0, 32'hDEAD_BEEF - 32'd129);
        send_rec(32'h0000_0010, 32'h0000_0000);
    endtask

    task automatic t_modes;
        set_mode(4'd5);
        set_mode(4'd3);
        @(posedge clk); #2;
        ek[n_exp] = 1; em[n_exp] = 4'd9; n_exp++; cur_mode = 4'd9;
        ek[n_exp] = 0; ea[n_exp] = 32'h0000_0020; ed[n_exp] = 32'h7FFF_FFFF;
        esa[n_exp] = 1; esd[n_exp] = 0; n_exp++;
        bp_a = 32'h0000_0020; bp_d = 32'h7FFF_FFFF;
        trace_mode = 4'd9; rec_valid = 1'b1; rec_addr = bp_a; rec_data = bp_d;
        @(posedge clk); #2;
        rec_valid = 1'b0;
        repeat (2) @(posedge clk);
        send_rec(32'h0000_0024, 32'h8000_0000);
    endtask

    task automatic t_decode;
        int pos = 0;
        logic [31:0] pa = '0, pd = '0;
        repeat (3) @(posedge clk); #2;
        flush_req = 1'b1;
        repeat (6) @(posedge clk); #2;
        flush_req = 1'b0;
        repeat (4) @(posedge clk);
        for (int i = 0; i < n_exp; i++) begin
            if (ek[i] == 1) begin
                chk(getb(pos, 2) == 32'd2, "R4 mode packet code", getb(pos, 2), 2);
                chk(getb(pos + 2, 4) == 32'(em[i]), "R4 mode value", getb(pos + 2, 4), 32'(em[i]));
                pos += 6;
            end else begin
                for (int f = 0; f < 2; f++) begin
                    logic [31:0] h = getb(pos, 2);
                    logic [31:0] v;
                    logic [31:0] ev = (f == 0) ? ea[i] : ed[i];
                    bit es = (f == 0) ? esa[i] : esd[i];
                    logic [31:0] pv = (f == 0) ? pa : pd;
                    chk(h == (es ? 32'd0 : 32'd1), "R2 packet form", h, es ? 0 : 1);
                    if (h == 32'd0) begin
                        logic [31:0] s = getb(pos + 2, 8);
                        v = pv + {{24{s[7]}}, s[7:0]};
                        pos += 10;
                    end else begin
                        v = getb(pos + 2, 32);
                        pos += 34;
                    end
                    chk(v == ev, "R3 rebuilt value", v, ev);
                    if (f == 0) pa = v; else pd = v;
                end
            end
        end
        chk(nwords == (pos + 31) / 32, "R6 word count after flush", 32'(nwords), 32'((pos + 31) / 32));
        chk(getb(pos, 32) == 32'd0, "R6 zero padding", getb(pos, 32), 0);
    endtask

    task automatic t_full;
        capture = 1'b0;
        for (int k = 0; k < 60 && !irq_seen; k++)
            send_rec(32'h8000_0000 + 32'(k) * 32'h0101_0000, ~(32'h8000_0000 + 32'(k) * 32'h0101_0000));
        chk(irq_seen == 1'b1, "R8 interrupt reached", 32'(irq_seen), 1);
        after_full = 0;
        for (int k = 0; k < 3; k++) send_rec(32'h1234_0000 << k, 32'h0F0F_0000 >> k);
        chk(after_full == 0, "R8 no write while full", 32'(after_full), 0);
        chk(irq_full == 1'b1, "R8 interrupt held", 32'(irq_full), 1);
        @(posedge clk); #2;
        irq_clear = 1'b1;
        @(posedge clk); #2;
        irq_clear = 1'b0; exp_waddr = 0; irq_seen = 1'b0;
        chk(irq_full == 1'b0, "R9 interrupt dropped", 32'(irq_full), 0);
        chk(mem_addr == '0, "R9 address restarted", 32'(mem_addr), 0);
        send_rec(32'hAAAA_0000, 32'h5555_0000);
        repeat (4) @(posedge clk);
        chk(exp_waddr >= 1, "R9 writes resume after clear", 32'(exp_waddr), 1);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        t_reset();
        #20 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        t_latency();
        t_deltas();
        t_modes();
        t_decode();
        t_full();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule